// File: doc/BRIEF.md
# Armed Trace Buffer Capture Controller

This block records a stream of 16-bit words into a 64-entry circular store while it is armed. Each capture strobe writes one word at the current write position. A 6-bit count reports how many entries hold valid data, and a sticky full flag reports that the store has wrapped at least once since the last arm. When the full flag is set, all 64 entries are valid whatever the count shows.

Software arms the controller with a configuration write. The same write selects one of two trigger modes and a break-enable setting. In begin-trigger mode, recording starts at the first trigger and ends by itself once 64 words are stored. At that point the controller pulses a disarm event and, if break-enable is set, a breakpoint request. In end-trigger mode, recording runs from the arm write, keeps overwriting the oldest word after a wrap, and stops on the trigger. A combinational read port takes an index that counts from the oldest valid word.

Top module: `trace_capture_ctrl`

## Requirements
- R1: After reset, the controller is disarmed, the count is 0, the full flag is 0, and neither disarm_evt nor brk_req is asserted.
- R2: A capture strobe or trigger has no effect while the controller is disarmed: the count, the full flag and armed stay unchanged.
- R3: Each accepted capture stores cap_data at the current write position and increments the count by one, modulo 64. With the full flag clear, a count of N means entries 0..N-1 hold the N words in capture order.
- R4: The full flag is set on the capture that takes the count from 63 to 0. It then stays set until the next arm write.
- R5: A configuration write with cfg_arm=1 sets armed, clears the count, the full flag and the write position, and latches cfg_end_mode (0 = begin-trigger, 1 = end-trigger) and cfg_brk_en. A capture strobe in that same cycle is not stored.
- R6: In begin-trigger mode, strobes before the first trigger are ignored. The strobe in the trigger cycle and every later strobe are stored.
- R7: In begin-trigger mode, the capture of the 64th word clears armed, pulses disarm_evt for one cycle and pulses brk_req in the same cycle only if cfg_brk_en was 1 at arming.
- R8: In end-trigger mode, capture continues past the wrap. Each new word overwrites the oldest one and the count keeps incrementing.
- R9: In end-trigger mode, a trigger while armed stores that cycle's strobe (if any) and then clears armed, pulsing disarm_evt for one cycle and never brk_req.
- R10: rd_data returns the entry at offset rd_idx from the oldest valid word. The oldest word is at the write position when the full flag is set, and at entry 0 otherwise.
- R11: A configuration write with cfg_arm=0 clears armed without pulsing disarm_evt or brk_req. A strobe in that same cycle is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_arm | input | 1 | Arm value written (1 arms and clears, 0 disarms) |
| cfg_end_mode | input | 1 | Trigger mode written: 0 begin-trigger, 1 end-trigger |
| cfg_brk_en | input | 1 | Break-enable written |
| trig | input | 1 | Trigger event |
| cap_stb | input | 1 | Capture strobe |
| cap_data | input | 16 | Word to record |
| rd_idx | input | 6 | Read offset from the oldest valid word |
| rd_data | output | 16 | Word at rd_idx |
| armed | output | 1 | Controller armed |
| count | output | 6 | Valid-word count |
| full | output | 1 | Sticky wrap flag |
| disarm_evt | output | 1 | One-cycle pulse when hardware clears armed |
| brk_req | output | 1 | One-cycle breakpoint request |

## Verification
The assertions check the following on every cycle: the count advances by exactly one per accepted capture, the full flag rises on the 63-to-0 wrap and then holds, an arm write clears the state, and disarmed strobes change nothing. They also check that brk_req comes only together with a hardware disarm and that a software disarm raises no event. Only the bench scenarios can show which strobes each trigger mode stores, the resulting contents read back in oldest-first order after a wrap, and whether the breakpoint appears for each break-enable setting.

// File: rtl/trc_pkg.sv
// Shared types for the trace capture controller.
// Assumes: the depth is a power of two, so pointers wrap naturally.
package trc_pkg;

    typedef enum logic {
        TRIG_BEGIN = 1'b0,   // record from the trigger until the store is full
        TRIG_END   = 1'b1    // record from arming until the trigger
    } trig_mode_e;

endpackage

// File: rtl/trc_arm_ctrl.sv
// Arming state machine: holds the armed bit, the latched mode and break
// enable, and decides which strobes are accepted as captures.
// Assumes: cfg_wr has priority over every capture in the same cycle, and
// at_last comes from the fill tracker (count equals its maximum).
module trc_arm_ctrl
    import trc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_wr,
    input  logic cfg_arm,
    input  logic cfg_end_mode,
    input  logic cfg_brk_en,
    input  logic trig,
    input  logic cap_stb,
    input  logic at_last,
    output logic armed,
    output logic cap_en,
    output logic clr,
    output logic disarm_evt,
    output logic brk_req
);

    trig_mode_e mode_q;
    logic       brk_en_q;
    logic       started_q;
    logic       window_open;

    // Recording window: end mode is open while armed; begin mode opens at the trigger.
    always_comb begin
        window_open = (mode_q == TRIG_END) || started_q || trig;
        cap_en      = armed && !cfg_wr && cap_stb && window_open;
        clr         = cfg_wr && cfg_arm;
    end

    // Arm state, mode latch and one-cycle disarm and breakpoint pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed      <= 1'b0;
            mode_q     <= TRIG_BEGIN;
            brk_en_q   <= 1'b0;
            started_q  <= 1'b0;
            disarm_evt <= 1'b0;
            brk_req    <= 1'b0;
        end else begin
            disarm_evt <= 1'b0;
            brk_req    <= 1'b0;
            if (cfg_wr) begin
                armed <= cfg_arm;
                if (cfg_arm) begin
                    mode_q    <= trig_mode_e'(cfg_end_mode);
                    brk_en_q  <= cfg_brk_en;
                    started_q <= 1'b0;
                end
            end else if (armed) begin
                if (mode_q == TRIG_BEGIN) begin
                    if (trig) begin
                        started_q <= 1'b1;
                    end
                    if (cap_en && at_last) begin
                        armed      <= 1'b0;
                        disarm_evt <= 1'b1;
                        brk_req    <= brk_en_q;
                    end
                end else if (trig) begin
                    armed      <= 1'b0;
                    disarm_evt <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/trc_fill_tracker.sv
// Valid-word count and sticky wrap flag. The count is also the write
// position, because both start at zero on arming and step together.
// Assumes: DEPTH is a power of two, so CNT_W bits wrap at DEPTH.
module trc_fill_tracker #(
    parameter int DEPTH = 64,
    localparam int CNT_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             cap_en,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             at_last
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(DEPTH - 1);

    // Flags the capture that completes a lap of the store.
    always_comb begin
        at_last = (count == LAST);
    end

    // Count update and full flag set on the wrap to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            full  <= 1'b0;
        end else if (clr) begin
            count <= '0;
            full  <= 1'b0;
        end else if (cap_en) begin
            count <= count + 1'b1;
            if (at_last) begin
                full <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/trc_store.sv
// Circular word store with one write port and one oldest-relative
// combinational read port.
// Assumes: wptr is the next slot to write; the store is not reset.
module trc_store #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 64,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wptr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              full,
    input  logic [PTR_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  base;
    logic [PTR_W-1:0]  rd_addr;

    // Oldest entry: the next write slot after a wrap, slot zero before it.
    always_comb begin
        base    = full ? wptr : '0;
        rd_addr = base + rd_idx;
        rd_data = mem[rd_addr];
    end

    // Writes one word per accepted capture.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wptr] <= wr_data;
        end
    end

endmodule

// File: rtl/trace_capture_ctrl.sv
// Top of the trace capture controller: connects the arming state machine,
// the fill tracker and the circular store.
// Assumes: a synchronous active-low reset and a single clock domain.
module trace_capture_ctrl #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 64,
    localparam int CNT_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_arm,
    input  logic              cfg_end_mode,
    input  logic              cfg_brk_en,
    input  logic              trig,
    input  logic              cap_stb,
    input  logic [DATA_W-1:0] cap_data,
    input  logic [CNT_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              armed,
    output logic [CNT_W-1:0]  count,
    output logic              full,
    output logic              disarm_evt,
    output logic              brk_req
);

    logic cap_en;
    logic clr;
    logic at_last;

    trc_arm_ctrl u_arm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_wr       (cfg_wr),
        .cfg_arm      (cfg_arm),
        .cfg_end_mode (cfg_end_mode),
        .cfg_brk_en   (cfg_brk_en),
        .trig         (trig),
        .cap_stb      (cap_stb),
        .at_last      (at_last),
        .armed        (armed),
        .cap_en       (cap_en),
        .clr          (clr),
        .disarm_evt   (disarm_evt),
        .brk_req      (brk_req)
    );

    trc_fill_tracker #(.DEPTH(DEPTH)) u_fill (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .cap_en  (cap_en),
        .count   (count),
        .full    (full),
        .at_last (at_last)
    );

    trc_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .wr_en   (cap_en),
        .wptr    (count),
        .wr_data (cap_data),
        .full    (full),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/trc_capture_checker.sv
// Cycle-level properties of the trace capture controller, bound to its top.
module trc_capture_checker #(
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_wr,
    input logic             cfg_arm,
    input logic             armed,
    input logic [CNT_W-1:0] count,
    input logic             full,
    input logic             disarm_evt,
    input logic             brk_req,
    input logic             cap_en
);

    logic arm_wr;
    assign arm_wr = cfg_wr && cfg_arm;

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !cfg_wr) |=> ($stable(count) && $stable(full)));

    assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> (count == CNT_W'($past(count) + 1'b1)));

    assert_full_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en && (count == {CNT_W{1'b1}})) |=> (full && count == '0));

    assert_full_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !arm_wr) |=> full);

    assert_arm_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        arm_wr |=> (armed && count == '0 && !full));

    assert_brk_with_disarm_R7: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> (disarm_evt && !armed));

    assert_disarm_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
        disarm_evt |-> (!armed && $past(armed)));

    assert_soft_disarm_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !cfg_arm) |=> (!armed && !disarm_evt && !brk_req));

endmodule

bind trace_capture_ctrl trc_capture_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .cfg_arm    (cfg_arm),
    .armed      (armed),
    .count      (count),
    .full       (full),
    .disarm_evt (disarm_evt),
    .brk_req    (brk_req),
    .cap_en     (cap_en)
);

// File: tb/trace_capture_ctrl_test.sv
module trace_capture_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic        cfg_arm = 1'b0;
    logic        cfg_end_mode = 1'b0;
    logic        cfg_brk_en = 1'b0;
    logic        trig = 1'b0;
    logic        cap_stb = 1'b0;
    logic [15:0] cap_data = '0;
    logic [5:0]  rd_idx = '0;
    logic [15:0] rd_data;
    logic        armed;
    logic [5:0]  count;
    logic        full;
    logic        disarm_evt;
    logic        brk_req;

    int checks = 0;
    int errors = 0;
    logic brk_seen = 1'b0;
    logic dis_seen = 1'b0;

    always #5 clk = ~clk;

    trace_capture_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_arm(cfg_arm),
        .cfg_end_mode(cfg_end_mode), .cfg_brk_en(cfg_brk_en), .trig(trig),
        .cap_stb(cap_stb), .cap_data(cap_data), .rd_idx(rd_idx),
        .rd_data(rd_data), .armed(armed), .count(count), .full(full),
        .disarm_evt(disarm_evt), .brk_req(brk_req)
    );

    // Scenario table: end mode, break enable, strobe count, trigger
    // strobe index (255 = none), expected count, full, armed, breakpoint.
    typedef struct packed {
        logic       end_m;
        logic       brk;
        logic [7:0] nstb;
        logic [7:0] trig_at;
        logic [5:0] e_cnt;
        logic       e_full;
        logic       e_armed;
        logic       e_brk;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b0, 8'd10,  8'd0,   6'd10, 1'b0, 1'b1, 1'b0},
        '{1'b0, 1'b0, 8'd10,  8'd4,   6'd6,  1'b0, 1'b1, 1'b0},
        '{1'b0, 1'b1, 8'd70,  8'd0,   6'd0,  1'b1, 1'b0, 1'b1},
        '{1'b0, 1'b0, 8'd70,  8'd2,   6'd0,  1'b1, 1'b0, 1'b0},
        '{1'b1, 1'b1, 8'd20,  8'd255, 6'd20, 1'b0, 1'b1, 1'b0},
        '{1'b1, 1'b1, 8'd80,  8'd255, 6'd16, 1'b1, 1'b1, 1'b0},
        '{1'b1, 1'b0, 8'd30,  8'd9,   6'd10, 1'b0, 1'b0, 1'b0},
        '{1'b0, 1'b1, 8'd5,   8'd255, 6'd0,  1'b0, 1'b1, 1'b0},
        '{1'b1, 1'b1, 8'd100, 8'd69,  6'd6,  1'b1, 1'b0, 1'b0}
    };

    // Records event pulses between checks.
    always @(negedge clk) begin
        if (brk_req)    brk_seen = 1'b1;
        if (disarm_evt) dis_seen = 1'b1;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic cfg_write(input logic arm, input logic endm, input logic brk, input logic stb);
        cfg_wr = 1'b1; cfg_arm = arm; cfg_end_mode = endm; cfg_brk_en = brk;
        cap_stb = stb;
        @(negedge clk);
        cfg_wr = 1'b0; cap_stb = 1'b0;
        brk_seen = 1'b0; dis_seen = 1'b0;
    endtask

    task automatic strobe(input logic [15:0] d, input logic t);
        cap_stb = 1'b1; cap_data = d; trig = t;
        @(negedge clk);
        cap_stb = 1'b0; trig = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual 0 expected 1");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state.
        chk("R1 armed", int'(armed), 0);
        chk("R1 count", int'(count), 0);
        chk("R1 full", int'(full), 0);
        chk("R1 brk_req", int'(brk_req), 0);

        // R2: strobes and trigger while disarmed change nothing.
        for (int i = 0; i < 3; i++) strobe(16'hdead, 1'b1);
        @(negedge clk);
        chk("R2 count", int'(count), 0);
        chk("R2 armed", int'(armed), 0);

        // Table scenarios (R3, R4, R6..R10).
        for (int v = 0; v < NVEC; v++) begin
            int first; int stored; int valid; int last;
            cfg_write(1'b1, VECS[v].end_m, VECS[v].brk, 1'b0);
            for (int i = 0; i < int'(VECS[v].nstb); i++)
                strobe(16'((v << 8) | i), (i == int'(VECS[v].trig_at)));
            @(negedge clk);
            chk($sformatf("R3 count vec%0d", v), int'(count), int'(VECS[v].e_cnt));
            chk($sformatf("R4 full vec%0d", v), int'(full), int'(VECS[v].e_full));
            chk($sformatf("R7 R9 armed vec%0d", v), int'(armed), int'(VECS[v].e_armed));
            chk($sformatf("R7 brk vec%0d", v), int'(brk_seen), int'(VECS[v].e_brk));
            chk($sformatf("R9 disarm_evt vec%0d", v), int'(dis_seen), int'(!VECS[v].e_armed));
            if (VECS[v].end_m) begin
                first  = 0;
                stored = (VECS[v].trig_at == 8'd255) ? int'(VECS[v].nstb) : int'(VECS[v].trig_at) + 1;
            end else begin
                first  = int'(VECS[v].trig_at);
                stored = (VECS[v].trig_at == 8'd255) ? 0 : int'(VECS[v].nstb) - first;
                if (stored > 64) stored = 64;
            end
            valid = (stored > 64) ? 64 : stored;
            last  = first + stored - 1;
            if (valid > 0) begin
                rd_idx = '0;
                #1;
                chk($sformatf("R10 oldest vec%0d", v), int'(rd_data), (v << 8) | (last - valid + 1));
                rd_idx = 6'(valid - 1);
                #1;
                chk($sformatf("R8 newest vec%0d", v), int'(rd_data), (v << 8) | last);
            end
        end

        // R6: a trigger without a strobe opens the window for later strobes.
        cfg_write(1'b1, 1'b0, 1'b0, 1'b0);
        strobe(16'h0001, 1'b0);
        trig = 1'b1; @(negedge clk); trig = 1'b0;
        for (int i = 0; i < 3; i++) strobe(16'h0a00 + 16'(i), 1'b0);
        @(negedge clk);
        chk("R6 count", int'(count), 3);
        rd_idx = '0; #1;
        chk("R6 first word", int'(rd_data), 16'h0a00);

        // R5: after a wrapped end-mode run, an arm write with a strobe clears everything.
        cfg_write(1'b1, 1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 70; i++) strobe(16'(i), 1'b0);
        chk("R8 full before rearm", int'(full), 1);
        cfg_write(1'b1, 1'b1, 1'b0, 1'b1);
        chk("R5 count", int'(count), 0);
        chk("R5 full", int'(full), 0);
        chk("R5 armed", int'(armed), 1);

        // R11: software disarm with a same-cycle strobe.
        for (int i = 0; i < 5; i++) strobe(16'(i), 1'b0);
        cfg_write(1'b0, 1'b1, 1'b0, 1'b1);
        for (int i = 0; i < 3; i++) strobe(16'h7777, 1'b0);
        @(negedge clk);
        chk("R11 count", int'(count), 5);
        chk("R11 armed", int'(armed), 0);
        chk("R11 disarm_evt", int'(dis_seen), 0);
        chk("R11 brk_req", int'(brk_seen), 0);

        finish_run();
    end

endmodule